// File: doc/BRIEF.md
# One-Time Lockable Security Register Unit

This unit holds the 512-byte security area that sits beside the main array of a serial EEPROM. The lower half of the area is a factory serial number. It is computed from parameters and cannot be written. The upper half is a 256-byte user area that software can program and then freeze for good. Only a power-on reset clears that freeze.

The serial engine decodes each command into strobes and passes them in. A `cmd_valid` pulse carries the opcode and the 24-bit address. Each `wr_valid` pulse carries one data byte. Each `rd_req` pulse asks for one byte, and `cmd_end` closes the command when chip select rises. The engine also supplies the write enable latch and the protection-mode bits. Address bit 10 gives each of the two security opcodes a second job. With the bit clear, the read opcode reads data. With it set, the same opcode reports the lock state. Likewise, the write opcode programs user bytes with the bit clear and performs the lock with the bit set.

Top module: `secreg_otp`

## Requirements
- R1: After reset, `rd_valid` is 0, the area is unlocked and every user byte (offsets 0x100 to 0x1FF) reads 0x00.
- R2: Opcode 0x83 with address bit 10 clear starts a read at offset `addr[8:0]`. Each `rd_req` makes `rd_valid` high for one cycle one clock later, with the byte at the current offset on `rd_data`. Serial byte i (offset i < 0x100) is (i*37 + 0xA5) mod 256. Offsets at or above 0x100 return user byte (offset - 0x100).
- R3: Successive read bytes step the offset by one, wrapping from 0x1FF to 0x000.
- R4: Opcode 0x82 with bit 10 clear and bit 8 set stores each data byte at the current offset. The offset then steps within the user page, wrapping from 0x1FF to 0x100.
- R5: A write command whose address has bit 8 clear (serial half) stores nothing.
- R6: Writes and lock commands are ignored when the write enable input is 0 at the command strobe.
- R7: With legacy protection selected and block-protect value 2'b11, user writes are refused. Any other block-protect value, or enhanced mode, lets them through.
- R8: Opcode 0x83 with bit 10 set returns 0x01 on every byte requested when locked, and 0x00 when unlocked.
- R9: Opcode 0x82 with bit 10 set locks the area only if bit 1 of the first data byte is 1. Later data bytes of that command have no effect.
- R10: Once locked, writes and further locks are ignored and user contents stay unchanged. Only reset clears the lock and the user bytes.
- R11: Address bits 23:11 and 9 are ignored. Under any other opcode, after `cmd_end`, and during a write or lock command, read requests return 0x00 and data bytes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | Command strobe: opcode and address valid |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | 24 | Address that follows the opcode |
| cmd_end | input | 1 | End of command (chip select released) |
| wr_valid | input | 1 | Data byte strobe |
| wr_data | input | 8 | Data byte |
| rd_req | input | 1 | Request for the next read byte |
| wel | input | 1 | Write enable latch state |
| legacy_wp | input | 1 | 1 = legacy protection mode, 0 = enhanced |
| bp | input | 2 | Legacy block-protect bits |
| rd_valid | output | 1 | Read byte valid, one cycle after `rd_req` |
| rd_data | output | 8 | Read byte |

## Verification
The assertions assume the serial engine raises at most one of `cmd_valid`, `wr_valid`, `rd_req` and `cmd_end` in a cycle. They also assume `wel`, `legacy_wp` and `bp` are settled when the command strobe arrives. The bench meets both conditions by driving each strobe from a task that raises one pulse per cycle on the falling edge. It sets the mode inputs together with the command strobe and keeps them until the next command. Within those limits the sweeps cover every security offset, every combination of enable, mode and block-protect value, and every confirmation-byte case of the lock.

// File: rtl/secreg_otp.sv
module secreg_otp #(
  parameter int          ADDR_W      = 24,
  parameter int          SPLIT_BIT   = 10,
  parameter logic [7:0]  OP_READ     = 8'h83,
  parameter logic [7:0]  OP_WRITE    = 8'h82,
  parameter logic [7:0]  SERIAL_SEED = 8'hA5,
  parameter logic [7:0]  SERIAL_STEP = 8'd37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_end,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic              wel,
  input  logic              legacy_wp,
  input  logic [1:0]        bp,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam int PAGE_W = 8;
  localparam int OFF_W  = PAGE_W + 1;
  localparam int PAGE_N = 1 << PAGE_W;

  typedef enum logic [2:0] {M_IDLE, M_READ, M_CHECK, M_WRITE, M_LOCK} mode_t;

  mode_t            mode_q, mode_d;
  logic [OFF_W-1:0] ptr_q;
  logic             locked_q;
  logic [7:0]       user_mem [PAGE_N];
  logic [7:0]       cur_byte;
  logic [7:0]       serial_byte;
  logic             unused_addr;

  assign unused_addr = ^{cmd_addr[ADDR_W-1:SPLIT_BIT+1], cmd_addr[SPLIT_BIT-1:OFF_W]};

  wire split_hi     = cmd_addr[SPLIT_BIT];
  wire legacy_block = legacy_wp && (bp == 2'b11);
  wire may_modify   = wel && !locked_q;
  wire mem_we       = wr_valid && !cmd_valid && (mode_q == M_WRITE);
  wire lock_fire    = wr_valid && !cmd_valid && (mode_q == M_LOCK);

  assign serial_byte = ptr_q[PAGE_W-1:0] * SERIAL_STEP + SERIAL_SEED;
  assign cur_byte    = ptr_q[PAGE_W] ? user_mem[ptr_q[PAGE_W-1:0]] : serial_byte;

  always_comb begin
    mode_d = M_IDLE;
    if (cmd_op == OP_READ)
      mode_d = split_hi ? M_CHECK : M_READ;
    else if (cmd_op == OP_WRITE) begin
      if (split_hi)
        mode_d = may_modify ? M_LOCK : M_IDLE;
      else if (may_modify && cmd_addr[PAGE_W] && !legacy_block)
        mode_d = M_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      ptr_q  <= '0;
    end else if (cmd_valid) begin
      mode_q <= mode_d;
      ptr_q  <= cmd_addr[OFF_W-1:0];
    end else if (cmd_end || lock_fire) begin
      mode_q <= M_IDLE;
    end else if (rd_req && mode_q == M_READ) begin
      ptr_q <= ptr_q + 1'b1;
    end else if (mem_we) begin
      ptr_q <= {1'b1, ptr_q[PAGE_W-1:0] + 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      locked_q <= 1'b0;
    else if (lock_fire && wr_data[1])
      locked_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_N; i++) user_mem[i] <= '0;
    end else if (mem_we) begin
      user_mem[ptr_q[PAGE_W-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        case (mode_q)
          M_READ:  rd_data <= cur_byte;
          M_CHECK: rd_data <= {7'b0, locked_q};
          default: rd_data <= 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/secreg_otp_check.sv
module secreg_otp_check (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_req,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       locked,
  input logic       in_check,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       mem_we,
  input logic       ptr_user
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_lock_confirm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(wr_valid && wr_data[1]));

  assert_status_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && in_check) |=> rd_data == {7'b0, $past(locked)});

  assert_write_user_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ptr_user && !locked));
endmodule

bind secreg_otp secreg_otp_check u_secreg_otp_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .locked   (locked_q),
  .in_check (mode_q == M_CHECK),
  .wr_valid (wr_valid),
  .wr_data  (wr_data),
  .mem_we   (mem_we),
  .ptr_user (ptr_q[8])
);

// File: tb/secreg_otp_bench.sv
`timescale 1ns/1ps
module secreg_otp_bench;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_end = 0, wr_valid = 0, rd_req = 0;
  logic [7:0]  cmd_op = 0, wr_data = 0;
  logic [23:0] cmd_addr = 0;
  logic        wel = 0, legacy_wp = 0;
  logic [1:0]  bp = 0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0, errors = 0;
  logic [7:0] umem [256];

  always #2.5 clk = ~clk;

  secreg_otp u_secreg_otp (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_end(cmd_end), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .wel(wel), .legacy_wp(legacy_wp),
    .bp(bp), .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic logic [7:0] exp_byte(input logic [8:0] off);
    logic [7:0] s;
    s = off[7:0] * 8'd37 + 8'hA5;
    return off[8] ? umem[off[7:0]] : s;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [23:0] a,
                     input logic w, input logic l, input logic [1:0] b);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; wel = w; legacy_wp = l; bp = b; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic fin();
    @(negedge clk); cmd_end = 1;
    @(negedge clk); cmd_end = 0;
  endtask

  task automatic wbyte(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_valid = 1;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic rbyte(input string req, input logic [7:0] exp);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk(req, {7'b0, rd_valid}, 8'h01);
    chk(req, rd_data, exp);
  endtask

  task automatic read_all(input string req);
    cmd(8'h83, 24'h000000, 0, 0, 0);
    for (int i = 0; i < 512; i++) rbyte(req, exp_byte(i[8:0]));
    fin();
  endtask

  task automatic lock_status(input string req, input logic [7:0] exp);
    cmd(8'h83, 24'h000400, 0, 0, 0);
    rbyte(req, exp); rbyte(req, exp);
    fin();
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 256; i++) umem[i] = 8'h00;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", {7'b0, rd_valid}, 8'h00);
    lock_status("R1 R8", 8'h00);
    read_all("R1 R2");

    // R3: wrap from top of the area back to offset 0
    cmd(8'h83, 24'h0001F0, 0, 0, 0);
    for (int i = 0; i < 528; i++) rbyte("R3", exp_byte(9'h1F0 + i[8:0]));
    fin();

    // R4: full page write starting mid-page, with wrap
    cmd(8'h82, 24'h000180, 1, 0, 0);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = i[7:0] * 8'd7 + 8'd3;
      wbyte(v);
      umem[8'h80 + i[7:0]] = v;
    end
    fin();
    read_all("R4");

    // R4: short wrap 0x1FE..0x101, don't-care address bits set (R11)
    cmd(8'h82, 24'hFFFBFE, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      wbyte(8'hC0 + i[7:0]);
      umem[8'hFE + i[7:0]] = 8'hC0 + i[7:0];
    end
    fin();
    cmd(8'h83, 24'hFFFBFE, 0, 0, 0);
    for (int i = 0; i < 4; i++) rbyte("R4 R11", exp_byte(9'h1FE + i[8:0]));
    fin();

    // R5: serial half not writable
    cmd(8'h82, 24'h000010, 1, 0, 0);
    wbyte(8'h00); wbyte(8'hFF);
    fin();
    cmd(8'h83, 24'h000010, 0, 0, 0);
    rbyte("R5", exp_byte(9'h010)); rbyte("R5", exp_byte(9'h011));
    fin();

    // R6 R7: enable/mode/protect sweep
    for (int c = 0; c < 16; c++) begin
      logic w, l; logic [1:0] b; logic [7:0] v;
      w = c[3]; l = c[2]; b = c[1:0]; v = 8'h40 + c[7:0];
      cmd(8'h82, 24'h000140, w, l, b);
      wbyte(v);
      fin();
      if (w && !(l && b == 2'b11)) umem[8'h40] = v;
      cmd(8'h83, 24'h000140, 0, 0, 0);
      rbyte(w ? "R7" : "R6", exp_byte(9'h140));
      fin();
    end

    // R11: reads return zero outside read modes; other opcodes ignore data
    cmd(8'h82, 24'h000150, 1, 0, 0);
    rbyte("R11", 8'h00);
    fin();
    cmd(8'h03, 24'h000150, 1, 0, 0);
    wbyte(8'h99); rbyte("R11", 8'h00);
    fin();
    rbyte("R11", 8'h00);
    cmd(8'h83, 24'h000150, 0, 0, 0);
    rbyte("R11", exp_byte(9'h150));
    fin();

    // R6 R9: lock attempts that must not take
    cmd(8'h82, 24'h000400, 0, 0, 0); wbyte(8'hFF); fin();
    lock_status("R6", 8'h00);
    cmd(8'h82, 24'h000400, 1, 0, 0); wbyte(8'hFD); fin();
    lock_status("R9", 8'h00);
    cmd(8'h82, 24'hFFFC00, 1, 0, 0); wbyte(8'h00); wbyte(8'h02); fin();
    lock_status("R9", 8'h00);
    cmd(8'h82, 24'h000400, 1, 1, 2'b11); wbyte(8'h02); fin();
    lock_status("R9 R8", 8'h01);

    // R10: locked area refuses writes and keeps contents
    cmd(8'h82, 24'h000100, 1, 0, 0);
    wbyte(8'h5A); wbyte(8'h5B);
    fin();
    cmd(8'h82, 24'h000400, 1, 0, 0); wbyte(8'h00); fin();
    lock_status("R10", 8'h01);
    read_all("R10");

    do_reset();
    lock_status("R10 R1", 8'h00);
    cmd(8'h83, 24'h000100, 0, 0, 0);
    for (int i = 0; i < 256; i++) rbyte("R10 R1", 8'h00);
    fin();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule